// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM Bank

This block models one bank of a synchronous static RAM whose word is 72 bits wide: eight 8-bit data lanes, each carrying its own parity bit. The rising clock edge samples every control, address and write-data input. The block has two address strobes. The host strobe registers a new address and starts a read, but it acts only while the bank is enabled. The controller strobe registers a new address and can also select or deselect the bank. A two-bit burst counter then walks the two lowest address bits. It steps in linear or interleaved order and can hold in wait cycles. The upper address bits stay at their registered value.

There is no output register. Read data comes straight from the array at the registered burst address, so it is valid in the same cycle the address is taken. An asynchronous output enable gates the drivers. A standby input freezes the bank and keeps its contents. Memory depth is set by the address width parameter.

Top module: `sbb_bank`

## Requirements
- R1: While reset is high and on the first cycle after it, the bank is deselected and `rd_drive` is 0. When `rd_drive` is 0, `rd_data` and `rd_par` read as zero.
- R2: When `host_strobe_n` and `bank_sel_n` are both low, the edge registers `addr_in`, selects the bank and starts a read at burst step 0. All write inputs are ignored in that cycle.
- R3: While `bank_sel_n` is high, `host_strobe_n` has no effect. With `ctl_strobe_n` high, the registered address and selection stay unchanged.
- R4: When `ctl_strobe_n` is low and the host strobe is not acting, the edge registers `addr_in` at burst step 0. The bank is selected if `bank_sel_n` is low and deselected if it is high. A selected bank writes the loaded address in the same edge if the write inputs request a write.
- R5: When both strobes are low in one cycle and the bank is enabled, the host strobe wins: the cycle is a read and nothing is written.
- R6: When `order_sel` = 0 (linear), each continuation cycle with `burst_step_n` low adds 1 to the low two address bits, modulo 4. Start 0 gives 0,1,2,3,0 and start 2 gives 2,3,0,1.
- R7: When `order_sel` = 1 (interleaved), the low two bits are the start bits XOR the step count 0,1,2,3. Start 1 gives 1,0,3,2.
- R8: A continuation cycle with `burst_step_n` high is a wait cycle. The burst address does not change.
- R9: `all_wr_n` low writes all eight lanes and all eight parity bits. The values of `lane_wr_en_n` and `lane_wr_n` do not matter.
- R10: With `all_wr_n` high and `lane_wr_en_n` low, each low bit `lane_wr_n[i]` writes data bits [8i+7:8i] and parity bit i. With `lane_wr_en_n` high, the lane lines write nothing. A continuation write goes to the burst address that results from that cycle's step or hold.
- R11: `rd_drive` = !`out_en_n` && selected && !`standby`, and it follows `out_en_n` without a clock edge. Read data for an address taken at an edge is valid right after that edge.
- R12: While `standby` is high, edges change no state and write nothing, and `rd_drive` is 0. Contents and the burst position are kept.
- R13: Bursting never changes address bits above bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | External word address |
| host_strobe_n | input | 1 | Host address strobe, active low, read-only load |
| ctl_strobe_n | input | 1 | Controller address strobe, active low, load with select/deselect |
| burst_step_n | input | 1 | Active low: step burst counter; high: wait cycle |
| bank_sel_n | input | 1 | Active-low bank enable |
| all_wr_n | input | 1 | Active-low full-word write |
| lane_wr_en_n | input | 1 | Active-low enable for the per-lane write lines |
| lane_wr_n | input | 8 | Active-low per-lane write lines |
| order_sel | input | 1 | Static burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| standby | input | 1 | Active-high low-power standby |
| wr_data | input | 64 | Write data, lane i on bits [8i+7:8i] |
| wr_par | input | 8 | Write parity, bit i belongs to lane i |
| rd_data | output | 64 | Flow-through read data |
| rd_par | output | 8 | Flow-through read parity |
| rd_drive | output | 1 | High while the outputs are driven |

## Verification
Address, selection and writes take effect at the edge that samples them. Because there is no output register, the matching read data is due in the same cycle, right after that edge. The bench therefore drives each vector on a falling edge, lets one rising edge pass and compares all outputs on the next falling edge. A burst row is expected to show the word at the address after that edge's step or hold. The output-enable and standby gating are combinational, so they are checked one time step after the input changes, with no clock edge in between.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

    localparam int LANES  = 8;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              par;
        logic [LANE_W-1:0] dat;
    } lane_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_HOST_LOAD,
        CYC_CTL_LOAD,
        CYC_CONT
    } cyc_e;

    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input order_e     ord);
        if (ord == ORD_INTERLEAVE)
            return start ^ step;
        return start + step;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic             full_n,
                                                   input logic             gate_n,
                                                   input logic [LANES-1:0] line_n);
        if (!full_n)
            return '1;
        if (!gate_n)
            return ~line_n;
        return '0;
    endfunction

endpackage

// File: rtl/sbb_ctrl.sv
module sbb_ctrl
    import sbb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic              host_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              burst_step_n,
    input  logic              bank_sel_n,
    input  order_e            ord,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              bank_sel,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_ok
);

    localparam int HI_W = ADDR_W - 2;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        step_q;
    logic [1:0]        step_nxt;
    logic              sel_q;
    cyc_e              cyc;

    always_comb begin
        if (!host_strobe_n && !bank_sel_n)
            cyc = CYC_HOST_LOAD;
        else if (!ctl_strobe_n)
            cyc = CYC_CTL_LOAD;
        else if (sel_q)
            cyc = CYC_CONT;
        else
            cyc = CYC_IDLE;
    end

    assign step_nxt = (cyc == CYC_CONT && !burst_step_n) ? 2'(step_q + 2'd1) : step_q;
    assign cur_addr = {base_q[ADDR_W-1 -: HI_W], burst_lo(base_q[1:0], step_q, ord)};
    assign bank_sel = sel_q;

    always_comb begin
        if (cyc == CYC_CTL_LOAD)
            wr_addr = addr_in;
        else
            wr_addr = {base_q[ADDR_W-1 -: HI_W], burst_lo(base_q[1:0], step_nxt, ord)};
    end

    assign wr_ok = !standby && ((cyc == CYC_CTL_LOAD && !bank_sel_n) || cyc == CYC_CONT);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            step_q <= '0;
            sel_q  <= 1'b0;
        end else if (!standby) begin
            case (cyc)
                CYC_HOST_LOAD: begin
                    base_q <= addr_in;
                    step_q <= '0;
                    sel_q  <= 1'b1;
                end
                CYC_CTL_LOAD: begin
                    base_q <= addr_in;
                    step_q <= '0;
                    sel_q  <= !bank_sel_n;
                end
                CYC_CONT: step_q <= step_nxt;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sbb_array.sv
module sbb_array
    import sbb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  lane_t [LANES-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output lane_t [LANES-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_t mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g])
                mem[wr_addr] <= wr_word[g];
        end

        assign rd_word[g] = mem[rd_addr];
    end

endmodule

// File: rtl/sbb_bank.sv
module sbb_bank
    import sbb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              host_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              burst_step_n,
    input  logic              bank_sel_n,
    input  logic              all_wr_n,
    input  logic              lane_wr_en_n,
    input  logic [7:0]        lane_wr_n,
    input  logic              order_sel,
    input  logic              out_en_n,
    input  logic              standby,
    input  logic [63:0]       wr_data,
    input  logic [7:0]        wr_par,
    output logic [63:0]       rd_data,
    output logic [7:0]        rd_par,
    output logic              rd_drive
);

    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic              bank_sel;
    logic              wr_ok;
    logic [LANES-1:0]  lane_we;
    lane_t [LANES-1:0] wr_word;
    lane_t [LANES-1:0] rd_word;
    order_e            ord;

    assign ord = order_e'(order_sel);

    sbb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .standby       (standby),
        .host_strobe_n (host_strobe_n),
        .ctl_strobe_n  (ctl_strobe_n),
        .burst_step_n  (burst_step_n),
        .bank_sel_n    (bank_sel_n),
        .ord           (ord),
        .addr_in       (addr_in),
        .cur_addr      (cur_addr),
        .bank_sel      (bank_sel),
        .wr_addr       (wr_addr),
        .wr_ok         (wr_ok)
    );

    assign lane_we  = wr_ok ? lane_mask(all_wr_n, lane_wr_en_n, lane_wr_n) : '0;
    assign rd_drive = !out_en_n && bank_sel && !standby;

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign wr_word[g].dat           = wr_data[g*LANE_W +: LANE_W];
        assign wr_word[g].par           = wr_par[g];
        assign rd_data[g*LANE_W +: LANE_W] = rd_drive ? rd_word[g].dat : '0;
        assign rd_par[g]                = rd_drive & rd_word[g].par;
    end

    sbb_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .lane_we (lane_we),
        .wr_addr (wr_addr),
        .wr_word (wr_word),
        .rd_addr (cur_addr),
        .rd_word (rd_word)
    );

endmodule

// File: rtl/sbb_bank_chk.sv
module sbb_bank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              standby,
    input logic              out_en_n,
    input logic              host_strobe_n,
    input logic              ctl_strobe_n,
    input logic              burst_step_n,
    input logic              bank_sel_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              bank_sel,
    input logic              rd_drive
);

    logic host_act;
    assign host_act = !host_strobe_n && !bank_sel_n;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !bank_sel && !rd_drive);

    assert_host_load_R2: assert property (@(posedge clk) disable iff (rst)
        (host_act && !standby) |=> bank_sel && cur_addr == $past(addr_in));

    assert_ctl_load_R4: assert property (@(posedge clk) disable iff (rst)
        (!host_act && !ctl_strobe_n && !standby)
            |=> bank_sel == !$past(bank_sel_n) && cur_addr == $past(addr_in));

    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!host_act && ctl_strobe_n && burst_step_n && !standby)
            |=> $stable(cur_addr) && $stable(bank_sel));

    assert_oe_gate_R11: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rd_drive);

    assert_standby_freeze_R12: assert property (@(posedge clk) disable iff (rst)
        standby |=> $stable(cur_addr) && $stable(bank_sel));

    assert_standby_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        standby |-> !rd_drive);

    assert_upper_keep_R13: assert property (@(posedge clk) disable iff (rst)
        (!host_act && ctl_strobe_n && bank_sel && !standby)
            |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

endmodule

bind sbb_bank sbb_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .standby       (standby),
    .out_en_n      (out_en_n),
    .host_strobe_n (host_strobe_n),
    .ctl_strobe_n  (ctl_strobe_n),
    .burst_step_n  (burst_step_n),
    .bank_sel_n    (bank_sel_n),
    .addr_in       (addr_in),
    .cur_addr      (cur_addr),
    .bank_sel      (bank_sel),
    .rd_drive      (rd_drive)
);

// File: tb/test_sbb_bank.sv
module test_sbb_bank;

    localparam int AW = 8;

    localparam logic [63:0] D1 = 64'h1111_1111_1111_1111;
    localparam logic [63:0] D2 = 64'h2222_2222_2222_2222;
    localparam logic [63:0] D3 = 64'h3333_3333_3333_3333;
    localparam logic [63:0] D4 = 64'h4444_4444_4444_4444;
    localparam logic [63:0] DX = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] DB = 64'h2222_2222_2222_22AA;
    localparam logic [63:0] D7 = 64'h7777_7777_7777_7777;

    typedef struct packed {
        logic        hs_n, cs_n, st_n, en_n, aw_n, le_n;
        logic [7:0]  lw_n;
        logic        ord;
        logic [7:0]  addr;
        logic [63:0] wd;
        logic [7:0]  wp;
        logic        edrv;
        logic [63:0] ed;
        logic [7:0]  ep;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1,0,1,0,0,1,8'hFF,0,8'h40,D1,8'h01,1,D1,8'h01,4'd4},     // R4 load+write 0x40
        '{1,1,0,0,0,1,8'hFF,0,8'h00,D2,8'h02,1,D2,8'h02,4'd6},     // R6 step -> 0x41
        '{1,1,0,0,0,1,8'hFF,0,8'h00,D3,8'h03,1,D3,8'h03,4'd6},     // R6 -> 0x42
        '{1,1,0,0,0,1,8'hFF,0,8'h00,D4,8'h04,1,D4,8'h04,4'd6},     // R6 -> 0x43
        '{1,1,0,0,1,1,8'hFF,0,8'h00,'0,8'h00,1,D1,8'h01,4'd6},     // R6 wrap -> 0x40
        '{0,1,1,0,0,1,8'hFF,0,8'h42,DX,8'hFF,1,D3,8'h03,4'd2},     // R2 write ignored
        '{1,1,0,0,1,1,8'hFF,0,8'h00,'0,8'h00,1,D4,8'h04,4'd6},     // R6 -> 0x43
        '{1,1,0,0,1,1,8'hFF,0,8'h00,'0,8'h00,1,D1,8'h01,4'd13},    // R13 wrap keeps upper
        '{1,1,1,0,1,1,8'hFF,0,8'h00,'0,8'h00,1,D1,8'h01,4'd8},     // R8 wait
        '{1,1,0,0,1,1,8'hFF,0,8'h00,'0,8'h00,1,D2,8'h02,4'd6},     // R6 -> 0x41
        '{0,1,1,0,1,1,8'hFF,1,8'h41,'0,8'h00,1,D2,8'h02,4'd7},     // R7 start 1
        '{1,1,0,0,1,1,8'hFF,1,8'h00,'0,8'h00,1,D1,8'h01,4'd7},     // R7 -> 0x40
        '{1,1,0,0,1,1,8'hFF,1,8'h00,'0,8'h00,1,D4,8'h04,4'd7},     // R7 -> 0x43
        '{1,1,0,0,1,1,8'hFF,1,8'h00,'0,8'h00,1,D3,8'h03,4'd7},     // R7 -> 0x42
        '{0,1,1,1,1,1,8'hFF,1,8'h43,'0,8'h00,1,D3,8'h03,4'd3},     // R3 ignored
        '{0,0,1,0,0,1,8'hFF,1,8'h40,DX,8'hFF,1,D1,8'h01,4'd5},     // R5 host wins
        '{1,0,1,0,1,0,8'hFE,0,8'h41,64'hAAAA_AAAA_AAAA_AAAA,8'hFF,1,DB,8'h03,4'd10}, // R10 lane 0
        '{1,0,1,0,1,1,8'h00,0,8'h41,DX,8'h55,1,DB,8'h03,4'd10},    // R10 gate off
        '{1,0,1,0,0,1,8'hFF,0,8'h42,D7,8'h77,1,D7,8'h77,4'd9},     // R9 full write
        '{1,0,1,1,1,1,8'hFF,0,8'h40,'0,8'h00,0,'0,8'h00,4'd4}      // R4 deselect
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [AW-1:0] addr_in;
    logic        host_strobe_n, ctl_strobe_n, burst_step_n, bank_sel_n;
    logic        all_wr_n, lane_wr_en_n, order_sel, out_en_n, standby;
    logic [7:0]  lane_wr_n;
    logic [63:0] wr_data;
    logic [7:0]  wr_par;
    logic [63:0] rd_data;
    logic [7:0]  rd_par;
    logic        rd_drive;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sbb_bank #(.ADDR_W(AW)) i_sbb_bank (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .host_strobe_n(host_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .burst_step_n(burst_step_n), .bank_sel_n(bank_sel_n),
        .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n),
        .order_sel(order_sel), .out_en_n(out_en_n), .standby(standby),
        .wr_data(wr_data), .wr_par(wr_par),
        .rd_data(rd_data), .rd_par(rd_par), .rd_drive(rd_drive)
    );

    task automatic chk(input string req, input logic [72:0] exp);
        logic [72:0] act;
        act = {rd_drive, rd_par, rd_data};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_strobe_n = 1'b1; ctl_strobe_n = 1'b1; burst_step_n = 1'b1;
        bank_sel_n = 1'b0; all_wr_n = 1'b1; lane_wr_en_n = 1'b1;
        lane_wr_n = 8'hFF; out_en_n = 1'b0; standby = 1'b0;
        addr_in = '0; wr_data = '0; wr_par = '0;
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        order_sel = 1'b0;
        rst = 1'b1;
        repeat (3) cycle();
        chk("R1 during reset", {1'b1, 8'h00, 64'h0} ^ {1'b1, 72'h0});
        rst = 1'b0;
        cycle();
        chk("R1 after reset", '0);

        for (int i = 0; i < NV; i++) begin
            host_strobe_n = VECS[i].hs_n;
            ctl_strobe_n  = VECS[i].cs_n;
            burst_step_n  = VECS[i].st_n;
            bank_sel_n    = VECS[i].en_n;
            all_wr_n      = VECS[i].aw_n;
            lane_wr_en_n  = VECS[i].le_n;
            lane_wr_n     = VECS[i].lw_n;
            order_sel     = VECS[i].ord;
            addr_in       = VECS[i].addr;
            wr_data       = VECS[i].wd;
            wr_par        = VECS[i].wp;
            cycle();
            chk($sformatf("R%0d row %0d", VECS[i].req, i),
                {VECS[i].edrv, VECS[i].ep, VECS[i].ed});
        end

        // R11: flow-through read, then asynchronous output enable
        idle();
        order_sel = 1'b0;
        host_strobe_n = 1'b0; addr_in = 8'h43;
        cycle();
        chk("R11 same-cycle read", {1'b1, 8'h04, D4});
        idle();
        out_en_n = 1'b1;
        #1;
        chk("R11 oe off", '0);
        out_en_n = 1'b0;
        #1;
        chk("R11 oe on", {1'b1, 8'h04, D4});

        // R12: standby freezes and blocks writes
        idle();
        host_strobe_n = 1'b0; addr_in = 8'h40;
        cycle();
        chk("R12 setup", {1'b1, 8'h01, D1});
        idle();
        standby = 1'b1; ctl_strobe_n = 1'b0; all_wr_n = 1'b0;
        addr_in = 8'h41; wr_data = DX; wr_par = 8'hFF;
        #1;
        chk("R12 outputs off", '0);
        cycle();
        chk("R12 still off", '0);
        idle();
        cycle();
        chk("R12 position kept", {1'b1, 8'h01, D1});
        host_strobe_n = 1'b0; addr_in = 8'h41;
        cycle();
        chk("R12 contents kept", {1'b1, 8'h03, DB});

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule